// File: doc/BRIEF.md
# Synchronous Trigger Command Receiver

This block sits on a front-end digitizer board behind the input buffers and the first capture flip-flop. Every cycle of the sample clock it samples a small group of trigger data lines, rebuilds a 4-bit command word from them, and treats the all-zero word as "nothing happened". For each real command it emits a one-cycle strobe toward the logic that acts on it: physics readout, raw-mode readout, scaler capture, test-pulse firing or timestamp synchronization.

A two-bit mode input selects how the lines carry a command. In single-line mode a high line is a plain physics trigger. In serial mode two lines carry half a word per cycle, framed by an internal phase bit that an align input restarts. In parallel mode four lines carry the whole word in one cycle. In legacy mode two lines act as separate TRIG and SYNC signals. Codes without a defined meaning are passed out on a generic strobe, and they, along with TRIG and SYNC seen together in legacy mode, advance a saturating error counter.

Top module: `trig_cmd_rx`

## Requirements
- R1: While reset (rstN low) is asserted, and after it is released until a command arrives, cmdValid, cmdCode, all strobes and errCount are zero, and the serial framing phase is at the first half.
- R2: With mode = 2 (parallel), the word is trigLines[3:0] sampled on one clock edge; its outputs appear in the cycle that follows that edge.
- R3: With mode = 1 (serial), a frame takes two consecutive samples of trigLines[1:0]: the first gives word bits [3:2], the second gives bits [1:0]; outputs appear in the cycle after the second sample, and trigLines[3:2] are ignored.
- R4: In serial mode a sample taken with align high is discarded, and the next sample is the first half of a new frame.
- R5: A word of 0 raises no strobe and leaves cmdValid low; cmdCode is 0 whenever cmdValid is low.
- R6: Code 1 raises physStrobe, 2 rawStrobe, 3 scalerStrobe, 4 pulseStrobe, 5 syncStrobe, each with cmdValid high and cmdCode equal to the code.
- R7: Codes 6 to 15 raise otherStrobe with cmdValid high and cmdCode equal to the code, and add one to errCount.
- R8: With mode = 0 (single line), each sample with trigLines[0] high produces code 1; trigLines[3:1] are ignored.
- R9: With mode = 3 (legacy), trigLines[0] is TRIG and produces code 1, trigLines[1] is SYNC and produces code 5; both high together produces no strobe and adds one to errCount.
- R10: Every strobe lasts exactly one cycle per command, and at most one strobe is high in any cycle.
- R11: errCount stops at its all-ones value and never decreases outside reset.
- R12: Outside serial mode the framing phase is held at the first half, so the first sample after entering serial mode is always a first half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Line format: 0 single, 1 serial, 2 parallel, 3 legacy |
| align | input | 1 | Restarts serial framing; the current sample is discarded |
| trigLines | input | 4 | Trigger data lines |
| cmdValid | output | 1 | A non-null command was decoded |
| cmdCode | output | 4 | Decoded command word, 0 when cmdValid is low |
| physStrobe | output | 1 | Normal physics trigger (code 1) |
| rawStrobe | output | 1 | Physics trigger with raw readout (code 2) |
| scalerStrobe | output | 1 | Scaler capture (code 3) |
| pulseStrobe | output | 1 | Fire test pulsers (code 4) |
| syncStrobe | output | 1 | Timestamp synchronization (code 5) |
| otherStrobe | output | 1 | Code 6 to 15 |
| errCount | output | ERR_W | Saturating count of unknown codes and legacy clashes |

## Verification
The bench goes after serial framing: half-frames interrupted by align, by a switch out of serial mode, and frames with a zero first or second half. A design that swapped the halves, restarted phase one cycle late or kept a stale phase across a mode change would emit wrong codes or strobe in the wrong cycle. It also drives TRIG and SYNC together in legacy mode, where a priority encoder instead of a clash check would fire a stray strobe, and it runs the error counter into its ceiling, where a wrapping counter would fall back to zero.

// File: rtl/trig_cmd_pkg.sv
package trig_cmd_pkg;

  localparam int CMD_W     = 4;
  localparam int SER_W     = CMD_W / 2;
  localparam int NUM_LINES = 4;
  localparam int NUM_KNOWN = 5;
  localparam int LEG_TRIG  = 0;
  localparam int LEG_SYNC  = 1;

  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'd0,
    MODE_SERIAL   = 2'd1,
    MODE_PARALLEL = 2'd2,
    MODE_LEGACY   = 2'd3
  } lineMode_e;

  localparam logic [CMD_W-1:0] CODE_NULL = 4'd0;
  localparam logic [CMD_W-1:0] CODE_PHYS = 4'd1;
  localparam logic [CMD_W-1:0] CODE_SYNC = 4'd5;

  typedef struct packed {
    logic loadHi;
    logic emitSerial;
    logic emitParallel;
    logic emitSingle;
    logic emitLegacy;
  } ctlStrobes_t;

endpackage

// File: rtl/trig_cmd_ctrl.sv
module trig_cmd_ctrl
  import trig_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  mode,
  input  logic        align,
  output ctlStrobes_t ctl
);

  logic      phase;
  lineMode_e lineMode;

  assign lineMode = lineMode_e'(mode);

  // Framing phase: 0 = first half expected, 1 = second half expected.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= 1'b0;
    end else if (lineMode != MODE_SERIAL || align) begin
      phase <= 1'b0;
    end else begin
      phase <= ~phase;
    end
  end

  always_comb begin
    ctl = '0;
    unique case (lineMode)
      MODE_SINGLE:   ctl.emitSingle   = 1'b1;
      MODE_PARALLEL: ctl.emitParallel = 1'b1;
      MODE_LEGACY:   ctl.emitLegacy   = 1'b1;
      MODE_SERIAL: begin
        if (!align) begin
          ctl.loadHi     = ~phase;
          ctl.emitSerial = phase;
        end
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/trig_cmd_dp.sv
module trig_cmd_dp
  import trig_cmd_pkg::*;
#(
  parameter int ERR_W = 8
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          ctl,
  input  logic [NUM_LINES-1:0] lines,
  output logic                 cmdValid,
  output logic [CMD_W-1:0]     cmdCode,
  output logic [NUM_KNOWN-1:0] knownStrb,
  output logic                 otherStrb,
  output logic [ERR_W-1:0]     errCount
);

  logic [SER_W-1:0] hiReg;
  logic [CMD_W-1:0] word;
  logic             clash;
  logic             isUnknown;
  logic             bump;
  logic             errFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hiReg <= '0;
    else if (ctl.loadHi) hiReg <= lines[SER_W-1:0];
  end

  always_comb begin
    word  = CODE_NULL;
    clash = 1'b0;
    if (ctl.emitSingle) begin
      word = lines[0] ? CODE_PHYS : CODE_NULL;
    end else if (ctl.emitSerial) begin
      word = {hiReg, lines[SER_W-1:0]};
    end else if (ctl.emitParallel) begin
      word = lines[CMD_W-1:0];
    end else if (ctl.emitLegacy) begin
      if (lines[LEG_TRIG] && lines[LEG_SYNC]) clash = 1'b1;
      else if (lines[LEG_TRIG])               word  = CODE_PHYS;
      else if (lines[LEG_SYNC])               word  = CODE_SYNC;
    end
  end

  assign isUnknown = (word > CMD_W'(NUM_KNOWN));
  assign bump      = isUnknown | clash;
  assign errFull   = &errCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid  <= 1'b0;
      cmdCode   <= '0;
      otherStrb <= 1'b0;
    end else begin
      cmdValid  <= (word != CODE_NULL);
      cmdCode   <= word;
      otherStrb <= isUnknown;
    end
  end

  for (genvar g = 0; g < NUM_KNOWN; g++) begin : gKnown
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) knownStrb[g] <= 1'b0;
      else       knownStrb[g] <= (word == CMD_W'(g + 1));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errCount <= '0;
    else if (bump && !errFull) errCount <= errCount + 1'b1;
  end

endmodule

// File: rtl/trig_cmd_rx.sv
module trig_cmd_rx
  import trig_cmd_pkg::*;
#(
  parameter int ERR_W = 8
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic             align,
  input  logic [3:0]       trigLines,
  output logic             cmdValid,
  output logic [3:0]       cmdCode,
  output logic             physStrobe,
  output logic             rawStrobe,
  output logic             scalerStrobe,
  output logic             pulseStrobe,
  output logic             syncStrobe,
  output logic             otherStrobe,
  output logic [ERR_W-1:0] errCount
);

  ctlStrobes_t          ctl;
  logic [NUM_KNOWN-1:0] knownStrb;

  trig_cmd_ctrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .mode  (mode),
    .align (align),
    .ctl   (ctl)
  );

  trig_cmd_dp #(.ERR_W(ERR_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .lines     (trigLines),
    .cmdValid  (cmdValid),
    .cmdCode   (cmdCode),
    .knownStrb (knownStrb),
    .otherStrb (otherStrobe),
    .errCount  (errCount)
  );

  assign physStrobe   = knownStrb[0];
  assign rawStrobe    = knownStrb[1];
  assign scalerStrobe = knownStrb[2];
  assign pulseStrobe  = knownStrb[3];
  assign syncStrobe   = knownStrb[4];

endmodule

// File: rtl/trig_cmd_rx_chk.sv
module trig_cmd_rx_chk #(
  parameter int ERR_W = 8
)(
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [3:0]       cmdCode,
  input logic             physStrobe,
  input logic             rawStrobe,
  input logic             scalerStrobe,
  input logic             pulseStrobe,
  input logic             syncStrobe,
  input logic             otherStrobe,
  input logic [ERR_W-1:0] errCount
);

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({physStrobe, rawStrobe, scalerStrobe, pulseStrobe, syncStrobe, otherStrobe}));

  a_r5_idle_code_zero: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> (cmdCode == 4'd0));

  a_r5_valid_nonnull: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdCode != 4'd0));

  a_r6_phys_code: assert property (@(posedge clk) disable iff (!rstN)
    physStrobe |-> (cmdValid && cmdCode == 4'd1));

  a_r6_sync_code: assert property (@(posedge clk) disable iff (!rstN)
    syncStrobe |-> (cmdValid && cmdCode == 4'd5));

  a_r7_other_range: assert property (@(posedge clk) disable iff (!rstN)
    otherStrobe |-> (cmdValid && cmdCode >= 4'd6));

  a_r7_other_counts: assert property (@(posedge clk) disable iff (!rstN)
    otherStrobe |-> ((errCount == ERR_W'($past(errCount) + 1'b1)) || (&errCount)));

  a_r11_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (&errCount) |=> (&errCount));

  a_r11_no_decrease: assert property (@(posedge clk) disable iff (!rstN)
    errCount >= $past(errCount));

endmodule

bind trig_cmd_rx trig_cmd_rx_chk #(.ERR_W(ERR_W)) uChk (.*);

// File: tb/trig_cmd_rx_test.sv
module trig_cmd_rx_test;

  localparam int ERR_W = 4;
  localparam int ERR_MAX = (1 << ERR_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] mode = 2'd0;
  logic align = 1'b0;
  logic [3:0] trigLines = 4'd0;
  logic cmdValid;
  logic [3:0] cmdCode;
  logic physStrobe, rawStrobe, scalerStrobe, pulseStrobe, syncStrobe, otherStrobe;
  logic [ERR_W-1:0] errCount;

  int checks = 0;
  int fails = 0;
  string curTag = "R1";

  // reference model state
  int mPhase = 0;
  int mHi = 0;
  int expCode = 0;
  int expOther = 0;
  int expErr = 0;

  always #2 clk = ~clk;

  trig_cmd_rx #(.ERR_W(ERR_W)) uut (
    .clk(clk), .rstN(rstN), .mode(mode), .align(align), .trigLines(trigLines),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .physStrobe(physStrobe),
    .rawStrobe(rawStrobe), .scalerStrobe(scalerStrobe), .pulseStrobe(pulseStrobe),
    .syncStrobe(syncStrobe), .otherStrobe(otherStrobe), .errCount(errCount)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mHi = 0; expCode = 0; expOther = 0; expErr = 0;
    end else begin
      int w;
      int clash;
      w = 0; clash = 0;
      case (mode)
        2'd0: w = trigLines[0] ? 1 : 0;
        2'd1: begin
          if (align) begin
            mPhase = 0;
          end else if (mPhase == 0) begin
            mHi = int'(trigLines[1:0]); mPhase = 1;
          end else begin
            w = mHi * 4 + int'(trigLines[1:0]); mPhase = 0;
          end
        end
        2'd2: w = int'(trigLines);
        default: begin
          if (trigLines[0] && trigLines[1]) clash = 1;
          else if (trigLines[0]) w = 1;
          else if (trigLines[1]) w = 5;
        end
      endcase
      if (mode != 2'd1) mPhase = 0;
      expCode = w;
      expOther = (w >= 6) ? 1 : 0;
      if ((w >= 6 || clash != 0) && expErr < ERR_MAX) expErr = expErr + 1;
    end
  end

  task automatic compare();
    logic [15:0] act, exp;
    act = {3'b0, cmdValid, cmdCode, physStrobe, rawStrobe, scalerStrobe,
           pulseStrobe, syncStrobe, otherStrobe, errCount};
    exp[15:13] = 3'b0;
    exp[12] = (expCode != 0);
    exp[11:8] = 4'(expCode);
    exp[7] = (expCode == 1);
    exp[6] = (expCode == 2);
    exp[5] = (expCode == 3);
    exp[4] = (expCode == 4);
    exp[3] = (expCode == 5);
    exp[2] = (expOther != 0);
    exp[1:0] = 2'b0;
    exp[15:4] = exp[15:4];
    exp = {exp[15:4] >> 0, 4'b0} | 16'(0);
    exp = {3'b0, exp[12], exp[11:8], exp[7:2], 4'(expErr)} ;
    exp = {3'b0, (expCode != 0), 4'(expCode), (expCode == 1), (expCode == 2),
           (expCode == 3), (expCode == 4), (expCode == 5), (expOther != 0), 4'(expErr)};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs {valid,code,phys,raw,scal,puls,sync,other,err} act=%h exp=%h",
               curTag, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] m, input logic a, input logic [3:0] l);
    mode = m; align = a; trigLines = l;
    @(negedge clk);
    compare();
  endtask

  initial begin : watchdog
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    curTag = "R1";
    repeat (3) begin @(negedge clk); compare(); end
    rstN = 1'b1;
    cyc(2'd2, 1'b0, 4'd0);
    cyc(2'd1, 1'b0, 4'd0);

    // R2 with R5 R6 R7: parallel sweep of every code
    cyc(2'd0, 1'b0, 4'd0);
    for (int c = 0; c < 16; c++) begin
      curTag = (c == 0) ? "R2 R5" : (c <= 5) ? "R2 R6" : "R2 R7";
      cyc(2'd2, 1'b0, 4'(c));
    end
    curTag = "R2 R10";
    cyc(2'd2, 1'b0, 4'd3);
    cyc(2'd2, 1'b0, 4'd3);
    cyc(2'd2, 1'b0, 4'd0);

    // R3: serial frames, high half first, upper lines ignored
    for (int c = 0; c < 16; c++) begin
      curTag = (c == 0) ? "R3 R5" : "R3";
      cyc(2'd1, 1'b0, {2'b11, 2'(c >> 2)});
      cyc(2'd1, 1'b0, {2'b10, 2'(c)});
    end

    // R4: align discards the sample and restarts framing
    curTag = "R4";
    cyc(2'd1, 1'b0, 4'd1);
    cyc(2'd1, 1'b1, 4'd2);
    cyc(2'd1, 1'b0, 4'd0);
    cyc(2'd1, 1'b0, 4'd2);
    cyc(2'd1, 1'b1, 4'd3);
    cyc(2'd1, 1'b1, 4'd3);
    cyc(2'd1, 1'b0, 4'd1);
    cyc(2'd1, 1'b0, 4'd0);

    // R12: leaving serial mid-frame resets the phase
    curTag = "R12";
    cyc(2'd1, 1'b0, 4'd1);
    cyc(2'd2, 1'b0, 4'd0);
    cyc(2'd1, 1'b0, 4'd1);
    cyc(2'd1, 1'b0, 4'd0);

    // R8: single line mode
    curTag = "R8";
    cyc(2'd0, 1'b0, 4'b1110);
    cyc(2'd0, 1'b0, 4'b0001);
    cyc(2'd0, 1'b0, 4'b1111);
    cyc(2'd0, 1'b1, 4'b0000);

    // R9: legacy TRIG/SYNC
    curTag = "R9";
    cyc(2'd3, 1'b0, 4'b0001);
    cyc(2'd3, 1'b0, 4'b0010);
    cyc(2'd3, 1'b0, 4'b0011);
    cyc(2'd3, 1'b0, 4'b1100);
    cyc(2'd3, 1'b0, 4'b0000);

    // R10: random mix across modes, checked every cycle
    curTag = "R10";
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[1:0], (r[7:4] == 4'd0), r[11:8]);
    end

    // R11: saturation of the error counter
    curTag = "R11";
    for (int i = 0; i < ERR_MAX + 4; i++) cyc(2'd2, 1'b0, 4'd15);
    cyc(2'd3, 1'b0, 4'b0011);
    cyc(2'd2, 1'b0, 4'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule